// File: doc/BRIEF.md
# PCI Slot Hotplug Controller

This block keeps the hotplug bookkeeping for a bank of PCI slots (32 by default). It holds three per-slot vectors. The first says a device sits in the slot. The second says the slot's device may be hot-removed. The third says a removal was requested and still waits for software to confirm it. Software sees these vectors through a small window of four 32-bit words. A sideband event port carries boot-time, hot-insert and hot-remove notices from the platform, each tagged with a slot number. A hot insert or a hot remove raises a one-cycle set pulse on a bit of the general event status, which the interrupt logic outside the block collects.

Software acknowledges a removal by writing a slot mask to the eject word. Only the lowest set bit of that write is acted on. A slot whose occupant is marked fixed (input `fixed_slots`) keeps its presence bit even when ejected. A platform reset request (`soft_rst`) starts a controlled sequence. First every outstanding removal is drained, one slot per clock. Then the removability vector is rebuilt from `fixed_slots` and the presence vector is reloaded from `occupied`. The same sequence runs when the hard reset `rst_n` is released.

The control state machine has three states. IDLE accepts events and eject writes. DRAIN clears the lowest pending slot each cycle. REBUILD reloads the vectors for one cycle. Its transitions are:
- IDLE to DRAIN on `soft_rst`.
- DRAIN to DRAIN while any removal is pending.
- DRAIN to REBUILD once nothing is pending.
- REBUILD to IDLE unconditionally.

The hard reset puts the machine in DRAIN with all vectors cleared.

Top module: `pci_hotplug_ctrl`

## Requirements
- R1: With `reg_idx` = 0 (byte offset 0x0), `rd_data` is the presence vector ANDed with the removability vector.
- R2: With `reg_idx` = 1 (offset 0x4), `rd_data` is the pending-removal vector.
- R3: With `reg_idx` = 2 (offset 0x8), `rd_data` is zero. With `reg_idx` = 3 (offset 0xC), `rd_data` is the removability vector.
- R4: An accepted event with `evt_kind` = 1 (hot insert) sets the slot's presence bit. In the following cycle `sts_set` is 0x02 (bit 1) for exactly one cycle.
- R5: An accepted event with `evt_kind` = 2 (hot remove) sets the slot's pending bit, pulses `sts_set` = 0x02, and leaves every presence bit unchanged.
- R6: An accepted event with `evt_kind` = 0 (boot-time insert) sets the slot's presence bit and leaves `sts_set` at zero. `evt_kind` = 3 does nothing.
- R7: A write with `reg_idx` = 2 in IDLE acts only on the lowest set bit of `wr_data`. It clears that slot's pending bit and clears its presence bit unless the slot is fixed. A zero write changes nothing.
- R8: Writes with `reg_idx` 0, 1 or 3 change no state.
- R9: After a `soft_rst` pulse with k removals pending, `busy` stays high for k+2 cycles. Afterwards the pending vector is zero, the removability vector is the inverse of `fixed_slots`, and the presence vector equals `occupied`.
- R10: While `busy` is high, events and eject writes are ignored and `sts_set` stays zero.
- R11: While `rst_n` is low, all vectors and `sts_set` are zero and `busy` is high. After release, `busy` stays high for exactly two cycles and the vectors are rebuilt as in R9.
- R12: When an eject write and an event hit the same cycle, the eject mask is applied first and the event's set second, so an event on the ejected slot prevails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| soft_rst | input | 1 | Platform reset request, one-cycle pulse |
| evt_valid | input | 1 | Sideband event strobe |
| evt_kind | input | 2 | 0 boot insert, 1 hot insert, 2 hot remove, 3 none |
| evt_slot | input | SLOT_W (5) | Slot number of the event |
| fixed_slots | input | NUM_SLOTS (32) | Slots whose device cannot be hot-removed |
| occupied | input | NUM_SLOTS (32) | Slot occupancy used when rebuilding |
| reg_idx | input | 2 | Word index of the register window (byte offset = 4 x index) |
| wr_en | input | 1 | Write strobe for the word selected by `reg_idx` |
| wr_data | input | REG_W (32) | Write data |
| rd_data | output | REG_W (32) | Read data of the selected word, combinational |
| sts_set | output | STS_W (8) | One-cycle set pulse for the event status bits |
| busy | output | 1 | High while the drain and rebuild sequence runs |

## Verification
The bench sweeps every one of the 32 slots in turn. For each slot it applies an insert (boot-time on even slots, hot on odd ones), then a hot remove, then an eject write whose data has all bits from that slot upward set. This separates the event kinds by their pulse and shows that only the lowest set bit of an eject is used. Fixed and non-fixed slots are mixed so that the masked up view and the removability view both differ from the plain presence vector. Writes to the other words, zero ejects, and ejects that collide with an event in the same cycle show where state is not touched and which update wins. A soft reset with three removals pending and an injected event during the drain tells an accepted event apart from an ignored one through the busy length and the final pending view.

// File: rtl/hp_pkg.sv
`timescale 1ns/1ps
package hp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_DRAIN   = 2'd1,
        ST_REBUILD = 2'd2
    } hp_state_e;

    typedef enum logic [1:0] {
        EV_BOOT   = 2'd0,
        EV_INSERT = 2'd1,
        EV_REMOVE = 2'd2,
        EV_NONE   = 2'd3
    } hp_evt_e;

    // word indices of the register window (byte offset = 4 * index)
    localparam logic [1:0] IDX_UP    = 2'd0;
    localparam logic [1:0] IDX_DOWN  = 2'd1;
    localparam logic [1:0] IDX_EJECT = 2'd2;
    localparam logic [1:0] IDX_RMV   = 2'd3;

endpackage

// File: rtl/hp_ctrl_fsm.sv
`timescale 1ns/1ps
module hp_ctrl_fsm
    import hp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic pend_any,
    output logic busy,
    output logic accept,
    output logic drain_en,
    output logic rebuild_en
);

    hp_state_e state_q;
    hp_state_e state_d;

    // state register: the hard reset enters the drain sequence
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_DRAIN;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    state_d = soft_rst ? ST_DRAIN : ST_IDLE;
            ST_DRAIN:   state_d = pend_any ? ST_DRAIN : ST_REBUILD;
            ST_REBUILD: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // outputs decoded from the current state
    always_comb begin
        busy       = 1'b1;
        accept     = 1'b0;
        drain_en   = 1'b0;
        rebuild_en = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy   = 1'b0;
                accept = 1'b1;
            end
            ST_DRAIN: begin
                drain_en = 1'b1;
            end
            ST_REBUILD: begin
                rebuild_en = 1'b1;
            end
            default: begin
                busy = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/hp_lowbit.sv
`timescale 1ns/1ps
module hp_lowbit #(
    parameter int W = 32
) (
    input  logic [W-1:0] vec_in,
    output logic [W-1:0] onehot
);

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    // two's complement isolates the least significant set bit
    assign onehot = vec_in & (~vec_in + ONE);

endmodule

// File: rtl/hp_slot_vectors.sv
`timescale 1ns/1ps
module hp_slot_vectors #(
    parameter int NUM_SLOTS = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rebuild_en,
    input  logic [NUM_SLOTS-1:0] clr_mask,
    input  logic [NUM_SLOTS-1:0] set_pres,
    input  logic [NUM_SLOTS-1:0] set_pend,
    input  logic [NUM_SLOTS-1:0] fixed_slots,
    input  logic [NUM_SLOTS-1:0] occupied,
    output logic [NUM_SLOTS-1:0] present,
    output logic [NUM_SLOTS-1:0] capable,
    output logic [NUM_SLOTS-1:0] pending
);

    logic [NUM_SLOTS-1:0] pres_d;
    logic [NUM_SLOTS-1:0] cap_d;
    logic [NUM_SLOTS-1:0] pend_d;

    // per-slot next state: clear first, then set; rebuild overrides both
    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        assign pres_d[i] = rebuild_en ? occupied[i]
                         : ((present[i] & ~(clr_mask[i] & ~fixed_slots[i])) | set_pres[i]);
        assign pend_d[i] = rebuild_en ? 1'b0
                         : ((pending[i] & ~clr_mask[i]) | set_pend[i]);
        assign cap_d[i]  = rebuild_en ? ~fixed_slots[i] : capable[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            present <= '0;
            capable <= '0;
            pending <= '0;
        end else begin
            present <= pres_d;
            capable <= cap_d;
            pending <= pend_d;
        end
    end

endmodule

// File: rtl/hp_reg_view.sv
`timescale 1ns/1ps
module hp_reg_view
    import hp_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int REG_W     = 32
) (
    input  logic [1:0]           reg_idx,
    input  logic [NUM_SLOTS-1:0] present,
    input  logic [NUM_SLOTS-1:0] capable,
    input  logic [NUM_SLOTS-1:0] pending,
    output logic [REG_W-1:0]     rd_data
);

    logic [NUM_SLOTS-1:0] sel;

    always_comb begin
        sel = '0;
        unique case (reg_idx)
            IDX_UP:    sel = present & capable;
            IDX_DOWN:  sel = pending;
            IDX_EJECT: sel = '0;
            IDX_RMV:   sel = capable;
            default:   sel = '0;
        endcase
    end

    always_comb begin
        rd_data                = '0;
        rd_data[NUM_SLOTS-1:0] = sel;
    end

endmodule

// File: rtl/pci_hotplug_ctrl.sv
`timescale 1ns/1ps
module pci_hotplug_ctrl
    import hp_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int REG_W     = 32,
    parameter int STS_W     = 8,
    parameter int STS_BIT   = 1,
    parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 soft_rst,
    input  logic                 evt_valid,
    input  logic [1:0]           evt_kind,
    input  logic [SLOT_W-1:0]    evt_slot,
    input  logic [NUM_SLOTS-1:0] fixed_slots,
    input  logic [NUM_SLOTS-1:0] occupied,
    input  logic [1:0]           reg_idx,
    input  logic                 wr_en,
    input  logic [REG_W-1:0]     wr_data,
    output logic [REG_W-1:0]     rd_data,
    output logic [STS_W-1:0]     sts_set,
    output logic                 busy
);

    localparam logic [STS_W-1:0] STS_MASK = STS_W'(1) << STS_BIT;

    logic                 accept;
    logic                 drain_en;
    logic                 rebuild_en;
    logic                 eject_ok;
    logic                 ev_go;
    hp_evt_e              kind;
    logic [NUM_SLOTS-1:0] present;
    logic [NUM_SLOTS-1:0] capable;
    logic [NUM_SLOTS-1:0] pending;
    logic [NUM_SLOTS-1:0] lb_src;
    logic [NUM_SLOTS-1:0] clr_mask;
    logic [NUM_SLOTS-1:0] slot_oh;
    logic [NUM_SLOTS-1:0] set_pres;
    logic [NUM_SLOTS-1:0] set_pend;

    hp_ctrl_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .pend_any   (|pending),
        .busy       (busy),
        .accept     (accept),
        .drain_en   (drain_en),
        .rebuild_en (rebuild_en)
    );

    assign kind     = hp_evt_e'(evt_kind);
    assign eject_ok = accept & wr_en & (reg_idx == IDX_EJECT);
    assign ev_go    = accept & evt_valid;

    // one lowest-bit finder serves both the drain walk and the eject word
    always_comb begin
        if (drain_en) begin
            lb_src = pending;
        end else if (eject_ok) begin
            lb_src = wr_data[NUM_SLOTS-1:0];
        end else begin
            lb_src = '0;
        end
    end

    hp_lowbit #(.W(NUM_SLOTS)) u_lowbit (
        .vec_in (lb_src),
        .onehot (clr_mask)
    );

    always_comb begin
        slot_oh           = '0;
        slot_oh[evt_slot] = 1'b1;
    end

    always_comb begin
        set_pres = '0;
        set_pend = '0;
        if (ev_go) begin
            unique case (kind)
                EV_BOOT, EV_INSERT: set_pres = slot_oh;
                EV_REMOVE:          set_pend = slot_oh;
                default:            set_pres = '0;
            endcase
        end
    end

    hp_slot_vectors #(.NUM_SLOTS(NUM_SLOTS)) u_vec (
        .clk         (clk),
        .rst_n       (rst_n),
        .rebuild_en  (rebuild_en),
        .clr_mask    (clr_mask),
        .set_pres    (set_pres),
        .set_pend    (set_pend),
        .fixed_slots (fixed_slots),
        .occupied    (occupied),
        .present     (present),
        .capable     (capable),
        .pending     (pending)
    );

    hp_reg_view #(.NUM_SLOTS(NUM_SLOTS), .REG_W(REG_W)) u_view (
        .reg_idx (reg_idx),
        .present (present),
        .capable (capable),
        .pending (pending),
        .rd_data (rd_data)
    );

    // status pulse for hot events only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts_set <= '0;
        end else if (ev_go && (kind == EV_INSERT || kind == EV_REMOVE)) begin
            sts_set <= STS_MASK;
        end else begin
            sts_set <= '0;
        end
    end

endmodule

// File: rtl/hp_checker.sv
`timescale 1ns/1ps
module hp_checker #(
    parameter int NUM_SLOTS = 32,
    parameter int STS_W     = 8,
    parameter int STS_BIT   = 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 busy,
    input logic                 evt_valid,
    input logic [1:0]           evt_kind,
    input logic                 wr_en,
    input logic [1:0]           reg_idx,
    input logic [STS_W-1:0]     sts_set,
    input logic [NUM_SLOTS-1:0] present,
    input logic [NUM_SLOTS-1:0] pending,
    input logic [NUM_SLOTS-1:0] fixed_slots
);

    localparam logic [STS_W-1:0] PULSE = STS_W'(1) << STS_BIT;

    // R4
    insert_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_kind == 2'd1 && !busy) |=> (sts_set == PULSE));

    // R6
    boot_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_kind == 2'd0 && !busy) |=> (sts_set == '0));

    // R5
    remove_keeps_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_kind == 2'd2 && !busy && !wr_en) |=> (present == $past(present)));

    // R7
    eject_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_idx == 2'd2 && !evt_valid && !busy)
        |=> (((present ^ $past(present)) & $past(fixed_slots)) == '0));

    // R10
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (sts_set == '0));

    // R10
    busy_no_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ((pending & ~$past(pending)) == '0));

    // R9
    drain_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (pending == '0));

endmodule

bind pci_hotplug_ctrl hp_checker #(
    .NUM_SLOTS (NUM_SLOTS),
    .STS_W     (STS_W),
    .STS_BIT   (STS_BIT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .evt_valid   (evt_valid),
    .evt_kind    (evt_kind),
    .wr_en       (wr_en),
    .reg_idx     (reg_idx),
    .sts_set     (sts_set),
    .present     (present),
    .pending     (pending),
    .fixed_slots (fixed_slots)
);

// File: tb/sim_pci_hotplug_ctrl.sv
`timescale 1ns/1ps
module sim_pci_hotplug_ctrl;

    localparam logic [31:0] FIXED = 32'h8000_0081;
    localparam logic [31:0] OCC1  = 32'h0000_F0F1;
    localparam logic [31:0] OCC2  = 32'h00FF_0003;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        soft_rst;
    logic        evt_valid;
    logic [1:0]  evt_kind;
    logic [4:0]  evt_slot;
    logic [31:0] fixed_slots;
    logic [31:0] occupied;
    logic [1:0]  reg_idx;
    logic        wr_en;
    logic [31:0] wr_data;
    logic [31:0] rd_data;
    logic [7:0]  sts_set;
    logic        busy;

    int          n_chk  = 0;
    int          n_fail = 0;
    logic [31:0] m_pres, m_cap, m_pend;
    logic [7:0]  last_sts;

    always #4 clk = ~clk;

    pci_hotplug_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .evt_valid(evt_valid), .evt_kind(evt_kind), .evt_slot(evt_slot),
        .fixed_slots(fixed_slots), .occupied(occupied),
        .reg_idx(reg_idx), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .sts_set(sts_set), .busy(busy)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] lowbit(input logic [31:0] v);
        return v & (~v + 32'd1);
    endfunction

    task automatic rd(input logic [1:0] idx, output logic [31:0] v);
        reg_idx = idx;
        #1;
        v = rd_data;
    endtask

    task automatic check_views(input string req);
        logic [31:0] v;
        rd(2'd0, v); chk(req, "R1 up view",        v, m_pres & m_cap);
        rd(2'd1, v); chk(req, "R2 down view",      v, m_pend);
        rd(2'd2, v); chk(req, "R3 eject readback", v, 32'h0);
        rd(2'd3, v); chk(req, "R3 removable view", v, m_cap);
    endtask

    task automatic step(input logic do_wr, input logic [1:0] idx, input logic [31:0] d,
                        input logic do_ev, input logic [1:0] k, input logic [4:0] s);
        @(negedge clk);
        wr_en     = do_wr;
        reg_idx   = idx;
        wr_data   = d;
        evt_valid = do_ev;
        evt_kind  = k;
        evt_slot  = s;
        @(negedge clk);
        wr_en     = 1'b0;
        evt_valid = 1'b0;
        last_sts  = sts_set;
    endtask

    // model of an eject followed by a same-cycle event set
    task automatic model_eject(input logic [31:0] d);
        logic [31:0] b;
        b = lowbit(d);
        m_pend = m_pend & ~b;
        m_pres = m_pres & ~(b & ~FIXED);
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int cnt;
        logic [31:0] b;
        rst_n = 1'b0; soft_rst = 1'b0; evt_valid = 1'b0; evt_kind = 2'd3;
        evt_slot = '0; fixed_slots = FIXED; occupied = OCC1;
        reg_idx = '0; wr_en = 1'b0; wr_data = '0;
        m_pres = '0; m_cap = '0; m_pend = '0;
        repeat (3) @(negedge clk);

        // R11 reset state
        chk("R11", "busy in reset", {31'b0, busy}, 32'd1);
        chk("R11", "sts in reset", {24'b0, sts_set}, 32'd0);
        check_views("R11");

        // R11 release: two busy cycles then rebuild
        @(negedge clk);
        rst_n = 1'b1;
        cnt = 0;
        while (busy && cnt < 100) begin
            cnt++;
            @(negedge clk);
        end
        chk("R11", "busy cycles after release", cnt, 32'd2);
        m_pres = OCC1; m_cap = ~FIXED; m_pend = '0;
        check_views("R11");

        // sweep every slot: insert, remove, eject with all higher bits set
        for (int s = 0; s < 32; s++) begin
            b = 32'h1 << s;
            if (s % 2 == 0) begin
                step(1'b0, 2'd0, 32'h0, 1'b1, 2'd0, 5'(s));
                chk("R6", "boot insert pulse", {24'b0, last_sts}, 32'h0);
                m_pres = m_pres | b;
                check_views("R6");
            end else begin
                step(1'b0, 2'd0, 32'h0, 1'b1, 2'd1, 5'(s));
                chk("R4", "hot insert pulse", {24'b0, last_sts}, 32'h2);
                @(negedge clk);
                chk("R4", "pulse width", {24'b0, sts_set}, 32'h0);
                m_pres = m_pres | b;
                check_views("R4");
            end
            step(1'b0, 2'd0, 32'h0, 1'b1, 2'd2, 5'(s));
            chk("R5", "hot remove pulse", {24'b0, last_sts}, 32'h2);
            m_pend = m_pend | b;
            check_views("R5");
            step(1'b1, 2'd2, ~(b - 32'd1), 1'b0, 2'd3, 5'd0);
            model_eject(~(b - 32'd1));
            check_views("R7");
        end

        // R6: kind 3 does nothing
        step(1'b0, 2'd0, 32'h0, 1'b1, 2'd3, 5'd13);
        chk("R6", "no-op kind pulse", {24'b0, last_sts}, 32'h0);
        check_views("R6");

        // R7: zero eject is a no-op
        step(1'b0, 2'd0, 32'h0, 1'b1, 2'd2, 5'd1);
        step(1'b0, 2'd0, 32'h0, 1'b1, 2'd2, 5'd4);
        step(1'b0, 2'd0, 32'h0, 1'b1, 2'd2, 5'd9);
        m_pend = m_pend | 32'h0000_0212;
        step(1'b1, 2'd2, 32'h0, 1'b0, 2'd3, 5'd0);
        check_views("R7");

        // R8: writes to the other words leave state alone
        step(1'b1, 2'd0, 32'hFFFF_FFFF, 1'b0, 2'd3, 5'd0);
        step(1'b1, 2'd1, 32'hFFFF_FFFF, 1'b0, 2'd3, 5'd0);
        step(1'b1, 2'd3, 32'hFFFF_FFFF, 1'b0, 2'd3, 5'd0);
        check_views("R8");

        // R12: eject and event in the same cycle
        step(1'b1, 2'd2, 32'h0000_0010, 1'b1, 2'd2, 5'd4);
        chk("R12", "collide pulse", {24'b0, last_sts}, 32'h2);
        model_eject(32'h0000_0010);
        m_pend = m_pend | 32'h0000_0010;
        check_views("R12");
        step(1'b1, 2'd2, 32'h0000_0200, 1'b1, 2'd1, 5'd12);
        model_eject(32'h0000_0200);
        m_pres = m_pres | 32'h0000_1000;
        check_views("R12");

        // three removals pending: slots 1, 4, 20
        step(1'b0, 2'd0, 32'h0, 1'b1, 2'd2, 5'd20);
        m_pend = m_pend | 32'h0010_0000;
        chk("R9", "pending before drain", m_pend, 32'h0010_0012);
        check_views("R9");

        // R9 / R10: soft reset, with an event and an eject while busy
        occupied = OCC2;
        @(negedge clk);
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst  = 1'b0;
        evt_valid = 1'b1; evt_kind = 2'd2; evt_slot = 5'd25;
        wr_en = 1'b1; reg_idx = 2'd2; wr_data = 32'hFFFF_FFFF;
        cnt = 0;
        while (busy && cnt < 100) begin
            cnt++;
            @(negedge clk);
            evt_valid = 1'b0;
            wr_en     = 1'b0;
            chk("R10", "pulse while busy", {24'b0, sts_set}, 32'h0);
        end
        chk("R9", "busy cycles for k=3", cnt, 32'd5);
        m_pres = OCC2; m_cap = ~FIXED; m_pend = '0;
        check_views("R9");
        check_views("R10");

        // back in idle, events work again
        step(1'b0, 2'd0, 32'h0, 1'b1, 2'd1, 5'd30);
        chk("R4", "insert after rebuild", {24'b0, last_sts}, 32'h2);
        m_pres = m_pres | 32'h4000_0000;
        check_views("R4");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule